// File: doc/BRIEF.md
# Two-Tap Line Video Output Formatter

This block sits between the pixel sequencer of a two-tap line-scan sensor and the parallel video pins of the camera. Each pixel-clock enable delivers one even-tap sample and one odd-tap sample, 12 bits each, together with a line-active flag. The block arranges these samples on an EVEN bus and an ODD bus. It also produces a beat strobe and a line-valid flag that qualify the data.

Configuration inputs choose the arrangement and the content. In the dual arrangement each tap keeps its own bus. In the single arrangement the two taps are interleaved onto the ODD bus at twice the rate, and the EVEN bus stays low. The format input keeps the top 12, 10 or 8 bits of each sample. A packed eight-bit mode puts the eight most significant bits of both taps side by side for a single connector. A test-pattern switch replaces the sensor data with a staircase that rises every 256 pixels. The configuration is expected to stay constant for the length of a line.

Top module: `line_video_formatter`

## Requirements
- R1: In the dual arrangement, a `pix_en` pulse produces a beat in the next cycle. During that beat `strobe` is high, `even_bus` carries the even sample and `odd_bus` carries the odd sample.
- R2: In the single arrangement, an accepted sample pair gives two beats in consecutive cycles on `odd_bus`: the even sample first, then the odd sample. `lval` holds its value across the two beats. A `pix_en` in the cycle of the second beat is ignored.
- R3: In the single arrangement, every bit of `even_bus` is 0 on every beat.
- R4: `fmt` code 0 passes all 12 bits. Code 1 outputs sample bits 11:2 on bus bits 9:0. Codes 2 and 3 output sample bits 11:4 on bus bits 7:0. Bus bits above the selected width are 0.
- R5: `lval` takes the value of `line_active` sampled with the pair. A beat whose pair was sampled with `line_active` low has `lval` low and both buses at 0.
- R6: With `test_pat` high, each sample is replaced by its pixel index within the line with the low 8 bits cleared, and then formatted as in R4. The index of even pixel k is 2k and of odd pixel k is 2k+1, counting pairs from 0 at the first pair of each line.
- R7: With `pack8` high, the dual arrangement and the 8-bit format are used, whatever the values of `single` and `fmt`.
- R8: After reset, and in every cycle without a beat, `strobe` is low. Reset drives `lval` and both buses to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-pair enable from the sequencer |
| line_active | input | 1 | High while the offered pair belongs to a line |
| even_pix | input | 12 | Even-tap sample |
| odd_pix | input | 12 | Odd-tap sample |
| single | input | 1 | 1 = interleave both taps onto the ODD bus |
| fmt | input | 2 | Output width: 0 = 12-bit, 1 = 10-bit, 2 or 3 = 8-bit |
| test_pat | input | 1 | 1 = replace sensor data with the staircase pattern |
| pack8 | input | 1 | 1 = dual 8-bit arrangement for one connector |
| even_bus | output | 12 | EVEN video bus |
| odd_bus | output | 12 | ODD video bus |
| strobe | output | 1 | High during each output beat |
| lval | output | 1 | Line valid, qualified by `strobe` |

## Verification
The assertions check four properties on every cycle. The EVEN bus stays silent in the single arrangement. The bits above the selected width stay zero. Beats outside a line carry no data. A beat always follows an enable in the dual arrangement, and the second beat of a single pair always follows the first. Only the bench can show that the correct values arrive in the correct order. This covers which tap comes first in the single arrangement, which bits survive the width reduction, and how the staircase index restarts at each line. The bench sweeps every format, arrangement and pattern setting across full lines.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;

    localparam int PIX_W     = 12;
    localparam int STEP_LOG2 = 8;
    localparam int DROP_10   = PIX_W - 10;
    localparam int DROP_8    = PIX_W - 8;

    typedef logic [PIX_W-1:0] pix_t;

    typedef enum logic [1:0] {
        FMT_W12 = 2'd0,
        FMT_W10 = 2'd1,
        FMT_W8  = 2'd2,
        FMT_W8B = 2'd3
    } fmt_e;

    typedef struct packed {
        pix_t ev;
        pix_t od;
    } pair_t;

    typedef struct packed {
        logic single;
        logic pack;
        logic test;
        fmt_e fmt;
    } cfg_t;

    function automatic pix_t fit_width(pix_t s, fmt_e f);
        pix_t r;
        case (f)
            FMT_W12: r = s;
            FMT_W10: r = s >> DROP_10;
            default: r = s >> DROP_8;
        endcase
        return r;
    endfunction

    function automatic cfg_t resolve_cfg(cfg_t c);
        cfg_t r;
        r = c;
        if (c.pack) begin
            r.single = 1'b0;
            r.fmt    = FMT_W8;
        end
        return r;
    endfunction

endpackage

// File: rtl/vfmt_index.sv
module vfmt_index #(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             line_on,
    output logic [IDX_W-1:0] idx_even
);
    localparam logic [IDX_W-1:0] PAIR_STEP = IDX_W'(2);

    logic [IDX_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (take) begin
            if (line_on) cnt_q <= cnt_q + PAIR_STEP;
            else         cnt_q <= '0;
        end
    end

    assign idx_even = cnt_q;
endmodule

// File: rtl/vfmt_select.sv
module vfmt_select
    import vfmt_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic [IDX_W-1:0] idx_even,
    input  logic             line_on,
    input  cfg_t             cfg,
    input  pair_t            raw,
    output pair_t            shaped
);
    localparam logic [IDX_W-1:0] STEP_MASK = ~((IDX_W'(1) << STEP_LOG2) - IDX_W'(1));

    logic [IDX_W-1:0] idx_odd;
    logic [IDX_W-1:0] step_ev, step_od;
    pix_t             pat_ev, pat_od;
    pair_t            src;

    assign idx_odd = idx_even | IDX_W'(1);
    assign step_ev = idx_even & STEP_MASK;
    assign step_od = idx_odd & STEP_MASK;

    generate
        if (IDX_W >= PIX_W) begin : g_wide_idx
            assign pat_ev = step_ev[IDX_W-1 -: PIX_W];
            assign pat_od = step_od[IDX_W-1 -: PIX_W];
        end else begin : g_narrow_idx
            localparam int PAD = PIX_W - IDX_W;
            assign pat_ev = {step_ev, {PAD{1'b0}}};
            assign pat_od = {step_od, {PAD{1'b0}}};
        end
    endgenerate

    always_comb begin
        if (cfg.test) begin
            src.ev = pat_ev;
            src.od = pat_od;
        end else begin
            src = raw;
        end
        if (line_on) begin
            shaped.ev = fit_width(src.ev, cfg.fmt);
            shaped.od = fit_width(src.od, cfg.fmt);
        end else begin
            shaped = '0;
        end
    end
endmodule

// File: rtl/vfmt_beat.sv
module vfmt_beat
    import vfmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pix_en,
    input  logic  line_on,
    input  logic  single,
    input  pair_t shaped,
    output logic  take,
    output logic  phase,
    output pix_t  even_q,
    output pix_t  odd_q,
    output logic  strobe_q,
    output logic  lval_q
);
    pix_t hold_q;
    logic phase_q;

    assign take  = pix_en & ~phase_q;
    assign phase = phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            even_q   <= '0;
            odd_q    <= '0;
            hold_q   <= '0;
            strobe_q <= 1'b0;
            lval_q   <= 1'b0;
            phase_q  <= 1'b0;
        end else if (take) begin
            strobe_q <= 1'b1;
            lval_q   <= line_on;
            phase_q  <= single;
            if (single) begin
                even_q <= '0;
                odd_q  <= shaped.ev;
                hold_q <= shaped.od;
            end else begin
                even_q <= shaped.ev;
                odd_q  <= shaped.od;
            end
        end else if (phase_q) begin
            strobe_q <= 1'b1;
            odd_q    <= hold_q;
            phase_q  <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
        end
    end
endmodule

// File: rtl/line_video_formatter.sv
module line_video_formatter
    import vfmt_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_en,
    input  logic              line_active,
    input  logic [PIX_W-1:0]  even_pix,
    input  logic [PIX_W-1:0]  odd_pix,
    input  logic              single,
    input  logic [1:0]        fmt,
    input  logic              test_pat,
    input  logic              pack8,
    output logic [PIX_W-1:0]  even_bus,
    output logic [PIX_W-1:0]  odd_bus,
    output logic              strobe,
    output logic              lval
);
    cfg_t             cfg_raw, cfg_eff;
    pair_t            raw_pair, shaped_pair;
    logic [IDX_W-1:0] idx_even;
    logic             take;
    logic             phase_q;

    assign cfg_raw  = '{single: single, pack: pack8, test: test_pat, fmt: fmt_e'(fmt)};
    assign cfg_eff  = resolve_cfg(cfg_raw);
    assign raw_pair = '{ev: even_pix, od: odd_pix};

    vfmt_index #(.IDX_W(IDX_W)) u_index (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .line_on  (line_active),
        .idx_even (idx_even)
    );

    vfmt_select #(.IDX_W(IDX_W)) u_select (
        .idx_even (idx_even),
        .line_on  (line_active),
        .cfg      (cfg_eff),
        .raw      (raw_pair),
        .shaped   (shaped_pair)
    );

    vfmt_beat u_beat (
        .clk      (clk),
        .rst      (rst),
        .pix_en   (pix_en),
        .line_on  (line_active),
        .single   (cfg_eff.single),
        .shaped   (shaped_pair),
        .take     (take),
        .phase    (phase_q),
        .even_q   (even_bus),
        .odd_q    (odd_bus),
        .strobe_q (strobe),
        .lval_q   (lval)
    );
endmodule

// File: rtl/vfmt_checker.sv
module vfmt_checker
    import vfmt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             pix_en,
    input logic             single,
    input logic             pack8,
    input logic [1:0]       fmt,
    input logic [PIX_W-1:0] even_bus,
    input logic [PIX_W-1:0] odd_bus,
    input logic             strobe,
    input logic             lval,
    input logic             phase
);
    AST_EVEN_MUTE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (strobe && single && !pack8) |-> (even_bus == '0)); // R3

    AST_FMT10_TOP_LOW: assert property (@(posedge clk) disable iff (rst)
        (strobe && fmt == 2'd1 && !pack8) |->
        (even_bus[PIX_W-1 -: DROP_10] == '0 && odd_bus[PIX_W-1 -: DROP_10] == '0)); // R4

    AST_FMT8_TOP_LOW: assert property (@(posedge clk) disable iff (rst)
        (strobe && (fmt[1] || pack8)) |->
        (even_bus[PIX_W-1 -: DROP_8] == '0 && odd_bus[PIX_W-1 -: DROP_8] == '0)); // R7

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        (strobe && !lval) |-> (even_bus == '0 && odd_bus == '0)); // R5

    AST_DUAL_BEAT: assert property (@(posedge clk) disable iff (rst)
        (pix_en && !phase && (!single || pack8)) |=> strobe); // R1

    AST_SECOND_BEAT: assert property (@(posedge clk) disable iff (rst)
        (strobe && phase) |=> (strobe && $stable(lval))); // R2
endmodule

bind line_video_formatter vfmt_checker u_vfmt_checker (
    .clk      (clk),
    .rst      (rst),
    .pix_en   (pix_en),
    .single   (single),
    .pack8    (pack8),
    .fmt      (fmt),
    .even_bus (even_bus),
    .odd_bus  (odd_bus),
    .strobe   (strobe),
    .lval     (lval),
    .phase    (phase_q)
);

// File: tb/test_line_video_formatter.sv
module test_line_video_formatter;
    localparam int LINE_PAIRS = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_en = 1'b0;
    logic        line_active = 1'b0;
    logic [11:0] even_pix = '0;
    logic [11:0] odd_pix = '0;
    logic        single = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic        test_pat = 1'b0;
    logic        pack8 = 1'b0;
    logic [11:0] even_bus, odd_bus;
    logic        strobe, lval;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    line_video_formatter i_line_video_formatter (
        .clk(clk), .rst(rst), .pix_en(pix_en), .line_active(line_active),
        .even_pix(even_pix), .odd_pix(odd_pix), .single(single), .fmt(fmt),
        .test_pat(test_pat), .pack8(pack8), .even_bus(even_bus),
        .odd_bus(odd_bus), .strobe(strobe), .lval(lval)
    );

    function automatic int fit(int v, int f);
        if (f == 0) return v;
        if (f == 1) return v >> 2;
        return v >> 4;
    endfunction

    function automatic int sample(int raw, int idx, bit tp, int f);
        int s;
        s = tp ? (idx & 32'hF00) : raw;
        return fit(s, f);
    endfunction

    task automatic chk(string tag, logic [25:0] got, logic [25:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got strobe/lval/even/odd %b/%b/%h/%h expected %b/%b/%h/%h",
                     tag, got[25], got[24], got[23:12], got[11:0],
                     exp[25], exp[24], exp[23:12], exp[11:0]);
        end
    endtask

    function automatic logic [25:0] pk(bit s, bit l, int e, int o);
        return {s, l, 12'(e), 12'(o)};
    endfunction

    task automatic run_line(int line_no);
        bit sgl;
        int f;
        sgl = single && !pack8;
        f   = pack8 ? 2 : int'(fmt);
        for (int k = 0; k < LINE_PAIRS; k++) begin
            int ev, od, xe, xo;
            ev = (k * 173 + line_no * 29 + 7) & 12'hFFF;
            od = (k * 311 + line_no * 53 + 1000) & 12'hFFF;
            xe = sample(ev, 2 * k, test_pat, f);
            xo = sample(od, 2 * k + 1, test_pat, f);
            pix_en = 1'b1; line_active = 1'b1;
            even_pix = 12'(ev); odd_pix = 12'(od);
            @(negedge clk);
            if (sgl) begin
                pix_en = 1'b0;
                chk(test_pat ? "R2 R3 R6 first beat" : "R2 R3 R4 first beat",
                    {strobe, lval, even_bus, odd_bus}, pk(1, 1, 0, xe));
                @(negedge clk);
                chk(test_pat ? "R2 R3 R6 second beat" : "R2 R3 R4 second beat",
                    {strobe, lval, even_bus, odd_bus}, pk(1, 1, 0, xo));
            end else begin
                chk(pack8 ? "R7 packed beat" : (test_pat ? "R1 R6 dual beat" : "R1 R4 dual beat"),
                    {strobe, lval, even_bus, odd_bus}, pk(1, 1, xe, xo));
            end
        end
        pix_en = 1'b1; line_active = 1'b0;
        even_pix = 12'hABC; odd_pix = 12'h123;
        @(negedge clk);
        pix_en = 1'b0;
        chk("R5 beat after line", {strobe, lval, even_bus, odd_bus}, pk(1, 0, 0, 0));
        if (sgl) begin
            @(negedge clk);
            chk("R5 second beat after line", {strobe, lval, even_bus, odd_bus}, pk(1, 0, 0, 0));
        end
        @(negedge clk);
        chk("R8 no beat idle", {strobe, lval}, {1'b0, 1'b0, 24'(0)} >> 24);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int line_no;
        line_no = 0;
        repeat (3) @(negedge clk);
        chk("R8 reset state", {strobe, lval, even_bus, odd_bus}, pk(0, 0, 0, 0));
        rst = 1'b0;
        @(negedge clk);
        chk("R8 idle after reset", {strobe, lval, even_bus, odd_bus}, pk(0, 0, 0, 0));

        for (int f = 0; f < 4; f++)
            for (int s = 0; s < 2; s++)
                for (int t = 0; t < 2; t++) begin
                    fmt = 2'(f); single = s[0]; test_pat = t[0]; pack8 = 1'b0;
                    @(negedge clk);
                    run_line(line_no);
                    line_no++;
                end

        for (int s = 0; s < 2; s++)
            for (int t = 0; t < 2; t++) begin
                fmt = 2'd0; single = s[0]; test_pat = t[0]; pack8 = 1'b1;
                @(negedge clk);
                run_line(line_no);
                line_no++;
            end

        // R2: enable during the second beat of a single pair is dropped
        pack8 = 1'b0; single = 1'b1; fmt = 2'd0; test_pat = 1'b0;
        @(negedge clk);
        pix_en = 1'b1; line_active = 1'b1; even_pix = 12'h111; odd_pix = 12'h222;
        @(negedge clk);
        even_pix = 12'h333; odd_pix = 12'h444;
        chk("R2 first beat", {strobe, lval, even_bus, odd_bus}, pk(1, 1, 0, 12'h111));
        @(negedge clk);
        pix_en = 1'b0;
        chk("R2 second beat keeps odd", {strobe, lval, even_bus, odd_bus}, pk(1, 1, 0, 12'h222));
        @(negedge clk);
        chk("R2 ignored enable gives no beat", {strobe, lval, even_bus, odd_bus}, pk(0, 1, 0, 12'h222));
        line_active = 1'b0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got no completion, expected end of sequence");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule